// File: doc/BRIEF.md
# Processor Bus Data Tenure Controller

This block follows the data phase of a split-transaction processor bus from the host bridge's point of view. An address tenure is handed to it through a valid/ready handshake together with its direction, its length (single beat or burst) and a per-transfer hit-delay value. From then on it decides three things. First, whether an external local-bus slave has taken the transfer. Second, when write data may be treated as valid on the shared 64-bit data bus. Third, when the bridge itself drives read data and its own transfer acknowledge. It also marks bridge-started snoop cycles as coherent.

The claim from the external slave is looked at exactly once. That happens when a small down-counter, loaded with the hit delay at address acceptance, runs out. A claim level left over from the previous clock is not honoured. The data tenure opens on the clock after data bus grant. It closes on the clock after the acknowledge that completes the beat count, or on the clock after a qualified address retry, whichever comes first.

Only one transfer is outstanding at a time. The address handshake applies back-pressure by dropping ready from the moment an address is taken until its tenure has been released. A source that raises valid keeps it raised, with stable attributes, until it sees ready high in the same cycle.

Top module: `dtenure_ctrl`

## Requirements
- R1: An address is taken on a clock where `addr_valid_i` and `addr_ready_o` are both high. `addr_ready_o` is low from the clock after acceptance until the clock after the tenure ends by completion or retry. While it is low, valid is ignored.
- R2: A data bus grant that arrives while an accepted address is waiting, with no tenure active and no qualified retry, opens the tenure on the next clock. For a write, `wdat_valid_o` is high from that clock.
- R3: During a tenure each `ta_i` counts one beat. A burst needs 4 beats and a single transfer needs 1. On the clock after the last beat, every tenure output is low and `done_o` pulses high for one clock.
- R4: A retry is qualified when `artry_i` is high while an address waits or a tenure is active. On the next clock all tenure state, the claim flag and the waiting address are cleared, and `done_o` stays low. A retry beats a `ta_i` in the same clock.
- R5: The claim input is sampled on the (H+1)-th clock edge after the acceptance edge, where H is the 3-bit `addr_hitdly_i` captured with the address (H=0 samples on the first edge after). `claimed_o` reflects the result from the clock after sampling until the tenure ends.
- R6: While `claimed_o` is high, `ack_en_o` and `dbus_oe_o` are low. For an unclaimed tenure whose claim has been sampled, `ack_en_o` is high, and `dbus_oe_o` is high for reads only.
- R7: A claim that was already high on the clock before the sampling clock is ignored, and `claimed_o` stays low.
- R8: `gbl_o` is high in the clock an address is accepted with `addr_snoop_i` or `addr_global_i` set, and low otherwise.
- R9: A data bus grant that arrives while a tenure is active raises `err_o` for one clock on the next clock and does not disturb the tenure. A grant with no waiting address is ignored.
- R10: While `rst_i` is high at a clock edge, all tenure state clears. After that edge `addr_ready_o` is high and every other output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_valid_i | input | 1 | Address tenure offered |
| addr_ready_o | output | 1 | Controller can take an address |
| addr_write_i | input | 1 | Transfer is a processor write |
| addr_burst_i | input | 1 | Transfer is a 4-beat burst |
| addr_snoop_i | input | 1 | Address is a snoop started by the bridge |
| addr_global_i | input | 1 | Requester marked the access coherent |
| addr_hitdly_i | input | 3 | Hit delay before the claim is sampled |
| dbg_i | input | 1 | Data bus grant |
| ta_i | input | 1 | Transfer acknowledge observed on the bus |
| artry_i | input | 1 | Address retry |
| claim_i | input | 1 | Local-bus slave claim |
| wdat_valid_o | output | 1 | Write data valid on the bus |
| dbus_oe_o | output | 1 | Bridge drives read data on the bus |
| ack_en_o | output | 1 | Bridge may drive transfer acknowledge |
| claimed_o | output | 1 | External slave owns this tenure |
| gbl_o | output | 1 | Coherency indicator for the accepted address |
| done_o | output | 1 | Tenure completed all beats (one-clock pulse) |
| err_o | output | 1 | Grant received during an active tenure |

## Verification
The hard collision is a retry that lands in the same clock as the acknowledge that would finish the tenure. Both events release the bus on the next clock, but only completion may pulse `done_o`. The bench drives `ta_i` and `artry_i` together on what would be the final beat. A behavioural per-clock model expects the release with no completion pulse, and this is confirmed by a named check on the following clock. A second overlap is a grant arriving during an open tenure. The bench judges it by `err_o` rising while the beat count and the release clock of the running tenure are unchanged.

// File: rtl/dtenure_pkg.sv
package dtenure_pkg;

  typedef struct packed {
    logic wr;
    logic burst;
  } xfer_t;

  function automatic int unsigned beat_cnt_w(input int unsigned beats);
    return (beats < 2) ? 1 : $clog2(beats);
  endfunction

endpackage

// File: rtl/dten_claim_unit.sv
module dten_claim_unit #(
  parameter int unsigned HD_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            start_i,
  input  logic [HD_W-1:0] hd_i,
  input  logic            clear_i,
  input  logic            claim_i,
  output logic            decided_o,
  output logic            claimed_o
);

  logic            armed;
  logic [HD_W-1:0] cnt;
  logic            claim_q;
  logic            decided;
  logic            claimed;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed   <= 1'b0;
      cnt     <= '0;
      claim_q <= 1'b0;
      decided <= 1'b0;
      claimed <= 1'b0;
    end else begin
      claim_q <= claim_i;
      if (clear_i) begin
        armed   <= 1'b0;
        decided <= 1'b0;
        claimed <= 1'b0;
      end else if (start_i) begin
        armed   <= 1'b1;
        cnt     <= hd_i;
        decided <= 1'b0;
        claimed <= 1'b0;
      end else if (armed) begin
        if (cnt == '0) begin
          armed   <= 1'b0;
          decided <= 1'b1;
          claimed <= claim_i & ~claim_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign decided_o = decided;
  assign claimed_o = claimed;

  // R7: a level held over from the previous clock never becomes a claim
  p_stale_claim_ignored_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed && cnt == '0 && claim_q && !clear_i && !start_i) |=> !claimed_o);

  // R5: a decision only appears after an armed countdown
  p_decide_from_armed_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(decided_o) |-> $past(armed));

endmodule

// File: rtl/dten_beat_unit.sv
module dten_beat_unit
  import dtenure_pkg::*;
#(
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic burst_i,
  input  logic ta_i,
  input  logic retry_i,
  input  logic grant_i,
  output logic active_o,
  output logic last_o,
  output logic done_o,
  output logic err_o
);

  localparam int unsigned BW = beat_cnt_w(BURST_BEATS);

  logic          active;
  logic [BW-1:0] beats;
  logic [BW-1:0] last_idx;
  logic          done_q;
  logic          err_q;

  assign last_idx = burst_i ? BW'(BURST_BEATS - 1) : '0;
  assign last_o   = active & ta_i & (beats == last_idx) & ~retry_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active <= 1'b0;
      beats  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= grant_i & active;
      if (retry_i) begin
        active <= 1'b0;
        beats  <= '0;
      end else if (active && ta_i) begin
        if (beats == last_idx) begin
          active <= 1'b0;
          beats  <= '0;
          done_q <= 1'b1;
        end else begin
          beats <= beats + 1'b1;
        end
      end else if (start_i) begin
        active <= 1'b1;
        beats  <= '0;
      end
    end
  end

  assign active_o = active;
  assign done_o   = done_q;
  assign err_o    = err_q;

  // R3: the beat index never runs past the programmed length
  p_beat_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    active |-> (beats <= last_idx));

  // R3: completion coincides with the bus already released
  p_done_released_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !active_o);

endmodule

// File: rtl/dtenure_ctrl.sv
module dtenure_ctrl
  import dtenure_pkg::*;
#(
  parameter int unsigned HD_W        = 3,
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            addr_valid_i,
  output logic            addr_ready_o,
  input  logic            addr_write_i,
  input  logic            addr_burst_i,
  input  logic            addr_snoop_i,
  input  logic            addr_global_i,
  input  logic [HD_W-1:0] addr_hitdly_i,
  input  logic            dbg_i,
  input  logic            ta_i,
  input  logic            artry_i,
  input  logic            claim_i,
  output logic            wdat_valid_o,
  output logic            dbus_oe_o,
  output logic            ack_en_o,
  output logic            claimed_o,
  output logic            gbl_o,
  output logic            done_o,
  output logic            err_o
);

  logic  pend;
  xfer_t xfer;
  logic  active;
  logic  last_beat;
  logic  decided;
  logic  claimed;
  logic  accept;
  logic  qual_retry;
  logic  start;

  assign addr_ready_o = ~pend & ~active;
  assign accept       = addr_valid_i & addr_ready_o;
  assign qual_retry   = artry_i & (pend | active);
  assign start        = dbg_i & pend & ~active & ~qual_retry;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend <= 1'b0;
      xfer <= '0;
    end else if (qual_retry || start) begin
      pend <= 1'b0;
    end else if (accept) begin
      pend       <= 1'b1;
      xfer.wr    <= addr_write_i;
      xfer.burst <= addr_burst_i;
    end
  end

  dten_claim_unit #(.HD_W(HD_W)) u_claim (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (accept),
    .hd_i      (addr_hitdly_i),
    .clear_i   (qual_retry | last_beat),
    .claim_i   (claim_i),
    .decided_o (decided),
    .claimed_o (claimed)
  );

  dten_beat_unit #(.BURST_BEATS(BURST_BEATS)) u_beat (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start),
    .burst_i  (xfer.burst),
    .ta_i     (ta_i),
    .retry_i  (qual_retry),
    .grant_i  (dbg_i),
    .active_o (active),
    .last_o   (last_beat),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  assign wdat_valid_o = active & xfer.wr;
  assign ack_en_o     = active & decided & ~claimed;
  assign dbus_oe_o    = active & decided & ~claimed & ~xfer.wr;
  assign claimed_o    = claimed;
  assign gbl_o        = accept & (addr_snoop_i | addr_global_i);

  // R2: a write grant with a waiting address gives valid data next clock
  p_grant_to_valid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (dbg_i && pend && !active && !artry_i && xfer.wr) |=> wdat_valid_o);

  // R4: a qualified retry leaves nothing open and reports no completion
  p_retry_clears_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (artry_i && (pend || active)) |=> (!active && !done_o && !claimed_o && addr_ready_o));

  // R6: a claimed tenure keeps the bridge off the bus
  p_claim_blocks_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    claimed_o |-> (!ack_en_o && !dbus_oe_o));

  // R8: bridge-started snoops are always coherent
  p_snoop_gbl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_valid_i && addr_ready_o && addr_snoop_i) |-> gbl_o);

  // R9: a grant during an open tenure is reported next clock
  p_grant_overlap_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (dbg_i && active) |=> err_o);

  // R1: no address is taken while ready is low
  p_ready_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (!addr_ready_o && !artry_i && !last_beat) |=> $stable(xfer));

endmodule

// File: tb/dtenure_ctrl_tb_top.sv
module dtenure_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       av = 0, wr = 0, bu = 0, sn = 0, gl = 0;
  logic [2:0] hd = '0;
  logic       dbg = 0, ta = 0, art = 0, clm = 0;

  logic ready, wval, oe, acken, claimed, gbl, done, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin   = 0;

  always #2.5 clk = ~clk;

  dtenure_ctrl dut_i (
    .clk_i (clk), .rst_i (rst),
    .addr_valid_i (av), .addr_ready_o (ready),
    .addr_write_i (wr), .addr_burst_i (bu),
    .addr_snoop_i (sn), .addr_global_i (gl),
    .addr_hitdly_i (hd),
    .dbg_i (dbg), .ta_i (ta), .artry_i (art), .claim_i (clm),
    .wdat_valid_o (wval), .dbus_oe_o (oe), .ack_en_o (acken),
    .claimed_o (claimed), .gbl_o (gbl), .done_o (done), .err_o (err)
  );

  // behavioural reference: edge counter and time stamps
  int k = 0;
  int samp = -1;
  int m_beats = 0;
  bit m_pend = 0, m_dten = 0, m_wr = 0, m_bu = 0;
  bit m_dec = 0, m_clm = 0, m_done = 0, m_err = 0, m_prevc = 0;

  always @(posedge clk) begin
    bit o_pend, o_dten, acc, qr;
    k++;
    if (rst) begin
      m_pend = 0; m_dten = 0; m_dec = 0; m_clm = 0;
      m_done = 0; m_err = 0; samp = -1; m_prevc = 0; m_beats = 0;
    end else begin
      o_pend = m_pend;
      o_dten = m_dten;
      acc    = av && !o_pend && !o_dten;
      qr     = art && (o_pend || o_dten);
      m_err  = dbg && o_dten;
      m_done = 0;
      if (qr) begin
        m_pend = 0; m_dten = 0; m_dec = 0; m_clm = 0; samp = -1;
      end else begin
        if (acc) begin
          m_pend = 1; m_wr = wr; m_bu = bu;
          samp = k + 1 + int'(hd); m_dec = 0; m_clm = 0;
        end else if (samp == k) begin
          m_dec = 1; m_clm = clm && !m_prevc; samp = -1;
        end
        if (o_dten && ta) begin
          m_beats++;
          if (m_beats == (m_bu ? 4 : 1)) begin
            m_dten = 0; m_done = 1; m_dec = 0; m_clm = 0; samp = -1;
          end
        end else if (dbg && o_pend && !o_dten) begin
          m_dten = 1; m_pend = 0; m_beats = 0;
        end
      end
      m_prevc = clm;
    end
  end

  task automatic chk(input string tag, input string nm, input logic a, input logic e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, a, e, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!fin) begin
      bit e_ready;
      e_ready = !m_pend && !m_dten;
      chk(rst ? "R10" : "R1", "addr_ready", ready, e_ready);
      chk(rst ? "R10" : "R2", "wdat_valid", wval, m_dten && m_wr);
      chk(rst ? "R10" : "R6", "ack_en", acken, m_dten && m_dec && !m_clm);
      chk(rst ? "R10" : "R6", "dbus_oe", oe, m_dten && m_dec && !m_clm && !m_wr);
      chk(rst ? "R10" : "R5", "claimed", claimed, m_clm);
      chk(rst ? "R10" : "R8", "gbl", gbl, av && e_ready && (sn || gl));
      chk(rst ? "R10" : "R3", "done", done, m_done);
      chk(rst ? "R10" : "R9", "err", err, m_err);
    end
  end

  task automatic drv(input logic v, input logic w, input logic b, input logic s,
                     input logic g, input int h, input logic d, input logic t,
                     input logic r, input logic c);
    @(posedge clk); #1;
    av = v; wr = w; bu = b; sn = s; gl = g; hd = 3'(h);
    dbg = d; ta = t; art = r; clm = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(0,0,0,0,0,0,0,0,0,0);
  endtask

  task automatic ack(input int n);
    for (int i = 0; i < n; i++) drv(0,0,0,0,0,0,0,1,0,0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R2 R3: single write, hit delay 0, no claim
    drv(1,1,0,0,0,0,0,0,0,0);
    idle(1);
    drv(0,0,0,0,0,0,1,0,0,0);
    idle(1);
    ack(1);
    idle(2);
    // R5 R6: claimed read burst, hit delay 2, claim on sampling clock
    drv(1,0,1,0,0,2,0,0,0,0);
    idle(2);
    drv(0,0,0,0,0,0,0,0,0,1);
    drv(0,0,0,0,0,0,1,0,0,0);
    ack(4);
    idle(2);
    // R1 R3 R6 R9: unclaimed read burst, gapped acks, overlap grant, busy valid
    drv(1,0,1,0,0,1,0,0,0,0);
    drv(1,0,0,0,0,0,0,0,0,0);
    drv(0,0,0,0,0,0,1,0,0,0);
    ack(1);
    idle(1);
    drv(0,0,0,0,0,0,1,1,0,0);
    idle(2);
    ack(2);
    idle(2);
    // R7: claim held across the sampling clock is ignored
    drv(1,0,0,0,0,1,0,0,0,0);
    drv(0,0,0,0,0,0,0,0,0,1);
    drv(0,0,0,0,0,0,0,0,0,1);
    idle(1);
    @(negedge clk) chk("R7", "stale claim", claimed, 1'b0);
    drv(0,0,0,0,0,0,1,0,0,0);
    ack(1);
    idle(2);
    // R4: retry together with the finishing acknowledge
    drv(1,0,0,0,0,0,0,0,0,0);
    drv(0,0,0,0,0,0,1,0,0,0);
    drv(0,0,0,0,0,0,0,1,1,0);
    idle(1);
    @(negedge clk) begin
      chk("R4", "done after retry", done, 1'b0);
      chk("R4", "oe after retry", oe, 1'b0);
    end
    idle(1);
    // R4 R9: retry while waiting for grant, then orphan grant
    drv(1,1,0,0,0,3,0,0,0,0);
    idle(1);
    drv(0,0,0,0,0,0,0,0,1,0);
    drv(0,0,0,0,0,0,1,0,0,0);
    idle(1);
    @(negedge clk) chk("R9", "orphan grant", wval, 1'b0);
    // R8: snoop then global addresses
    drv(1,0,0,1,0,0,0,0,0,0);
    drv(0,0,0,0,0,0,0,0,1,0);
    idle(1);
    // R5: write burst, hit delay 7, claim on the 8th clock
    drv(1,1,1,0,1,7,0,0,0,0);
    idle(7);
    drv(0,0,0,0,0,0,0,0,0,1);
    drv(0,0,0,0,0,0,1,0,0,0);
    ack(4);
    idle(2);
    // R10: reset in the middle of a tenure
    drv(1,0,0,0,0,0,0,0,0,0);
    drv(0,0,0,0,0,0,1,0,0,0);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    idle(3);
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule